// File: doc/BRIEF.md
# Coprocessor Issue Synchronization Interlock

This block sits at the issue point between an in-order integer pipeline and a floating-point coprocessor. Each cycle it sees one decoded instruction class tag with an issue valid, and decides whether the instruction is accepted, sent to the coprocessor, held back, or turned into an illegal-instruction trap. Instructions that work only on floating-point state are dispatched and then left to run in the background. Later integer instructions keep flowing, so a long operation such as a divide is hidden behind integer work.

Instructions that touch state shared with the integer side are synchronizing. These are loads and stores that take an address from, or update, a general register, compares that write the condition bit, and moves to or from the transfer and status registers. Such an instruction first waits for any earlier coprocessor operation to finish. After it is dispatched, every following instruction is held until it completes. The coprocessor latency of each instruction is given as an input count, and the block tracks the remaining busy cycles itself.

A standby control register turns the coprocessor off. While standby is set, every coprocessor instruction is accepted as an illegal-instruction trap and is not dispatched.

Top module: `cop_issue_interlock`

## Requirements
- R1: The class tag uses this encoding: 0 is a plain integer instruction, 1 is a coprocessor instruction that touches only floating-point state, 2 is a synchronizing floating-point instruction, and 3 is a coprocessor-related integer instruction, which is also synchronizing. A class 0 instruction is accepted in the cycle it is presented whenever no synchronizing operation is in flight. It never raises cop_dispatch or illegal_req.
- R2: While standby is clear, a class 1 instruction presented to an idle coprocessor is dispatched in that same cycle. Class 0 instructions presented while it runs are accepted without stall.
- R3: A dispatch in cycle t with latency L keeps cop_busy high in cycles t+1 through t+L. It is low again from cycle t+L+1.
- R4: A class 1, 2 or 3 instruction presented while cop_busy is high, with standby clear, is stalled. It is dispatched in the first cycle in which cop_busy is low.
- R5: After a class 2 or 3 instruction is dispatched, every instruction, including class 0, is stalled for as long as cop_busy stays high.
- R6: A write to the standby register sets the standby state to bit 1 of the written data. The other data bits have no effect. The write takes effect for instructions presented from the next cycle on, and standby resets to 0.
- R7: While standby is set, a class 1, 2 or 3 instruction that is not held by R5 is accepted with illegal_req high in that cycle. It is not dispatched, and the coprocessor busy state is left unchanged.
- R8: stall is high exactly when iss_valid is high and iss_ready is low.
- R9: A dispatch with latency 0 leaves cop_busy low. The next instruction, of any class, is accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction presented this cycle |
| iss_class | input | 2 | Instruction class tag (R1 encoding) |
| iss_lat | input | LAT_W | Coprocessor latency of the presented instruction |
| iss_ready | output | 1 | Instruction is accepted this cycle |
| stall | output | 1 | Integer side must hold the presented instruction |
| cop_dispatch | output | 1 | Instruction is sent to the coprocessor this cycle |
| cop_busy | output | 1 | A dispatched coprocessor operation is still running |
| illegal_req | output | 1 | Illegal-instruction exception request |
| sby_we | input | 1 | Write strobe for the standby register |
| sby_wdata | input | 8 | Standby register write data, bit 1 is standby |

## Verification
The handshake outputs iss_ready, stall, cop_dispatch and illegal_req are combinational. They are due in the same cycle the instruction is presented. The bench drives inputs at the falling edge and compares these outputs one time unit later against a behavioural model. cop_busy and the standby state change only at the rising edge. The model is updated on that edge, so each check sees the busy window of R3 (cycles t+1 to t+L) and the standby write of R6 exactly one cycle after its cause. Directed sequences cover overlap, waiting behind a busy operation, holding after a synchronizing dispatch, latency 0 and standby traps. A long pseudo-random phase follows and is compared on every cycle.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

  typedef enum logic [1:0] {
    CLS_INT    = 2'd0,
    CLS_FPLOC  = 2'd1,
    CLS_FPSYNC = 2'd2,
    CLS_COPINT = 2'd3
  } cls_e;

  localparam int SBY_BIT = 1;

  function automatic logic cls_uses_cop(logic [1:0] c);
    return c != CLS_INT;
  endfunction

  function automatic logic cls_needs_sync(logic [1:0] c);
    return c == CLS_FPSYNC || c == CLS_COPINT;
  endfunction

endpackage

// File: rtl/cpi_standby_reg.sv
module cpi_standby_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          standby
);
  import cpi_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)  standby <= 1'b0;
    else if (we) standby <= wdata[SBY_BIT];
  end

  AST_STANDBY_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> standby == $past(wdata[SBY_BIT])); // R6
  AST_STANDBY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(standby)); // R6

endmodule

// File: rtl/cpi_busy_track.sv
module cpi_busy_track #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_lat,
  input  logic             load_sync,
  output logic             busy,
  output logic             sync_hold
);
  logic [LAT_W-1:0] remain;
  logic             last_cycle;

  assign busy       = remain != '0;
  assign last_cycle = remain == LAT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain    <= '0;
      sync_hold <= 1'b0;
    end else if (load) begin
      remain    <= load_lat;
      sync_hold <= load_sync && (load_lat != '0);
    end else if (busy) begin
      remain <= remain - LAT_W'(1);
      if (last_cycle) sync_hold <= 1'b0;
    end
  end

  AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain == $past(load_lat)); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !load |=> remain == $past(remain) - LAT_W'(1)); // R3
  AST_HOLD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hold |-> busy); // R5

endmodule

// File: rtl/cpi_issue_decide.sv
module cpi_issue_decide (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic [1:0] cls,
  input  logic       standby,
  input  logic       busy,
  input  logic       sync_hold,
  output logic       ready,
  output logic       stall,
  output logic       dispatch,
  output logic       illegal,
  output logic       wants_sync
);
  import cpi_pkg::*;

  logic uses_cop;
  logic cop_live;
  logic waits_cop;

  always_comb begin
    uses_cop   = cls_uses_cop(cls);
    wants_sync = cls_needs_sync(cls);
    cop_live   = uses_cop && !standby;
    waits_cop  = busy && (sync_hold || cop_live);
    ready      = !waits_cop;
    stall      = valid && waits_cop;
    dispatch   = valid && ready && cop_live;
    illegal    = valid && ready && uses_cop && standby;
  end

  AST_NO_DISPATCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> !busy); // R4
  AST_TRAP_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(dispatch && illegal)); // R7
  AST_SYNC_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hold |-> !ready); // R5
  AST_INT_OVERLAPS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && cls == CLS_INT && !sync_hold |-> ready && !dispatch && !illegal); // R2
  AST_STANDBY_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !dispatch); // R7

endmodule

// File: rtl/cop_issue_interlock.sv
module cop_issue_interlock #(
  parameter int LAT_W = 4,
  parameter int SBY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [1:0]       iss_class,
  input  logic [LAT_W-1:0] iss_lat,
  output logic             iss_ready,
  output logic             stall,
  output logic             cop_dispatch,
  output logic             cop_busy,
  output logic             illegal_req,
  input  logic             sby_we,
  input  logic [SBY_W-1:0] sby_wdata
);
  logic standby_q;
  logic busy_w;
  logic hold_w;
  logic sync_w;

  cpi_standby_reg #(.DW(SBY_W)) u_sby (
    .clk(clk), .rst_n(rst_n), .we(sby_we), .wdata(sby_wdata), .standby(standby_q)
  );

  cpi_issue_decide u_dec (
    .clk(clk), .rst_n(rst_n), .valid(iss_valid), .cls(iss_class),
    .standby(standby_q), .busy(busy_w), .sync_hold(hold_w),
    .ready(iss_ready), .stall(stall), .dispatch(cop_dispatch),
    .illegal(illegal_req), .wants_sync(sync_w)
  );

  cpi_busy_track #(.LAT_W(LAT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(cop_dispatch), .load_lat(iss_lat),
    .load_sync(sync_w), .busy(busy_w), .sync_hold(hold_w)
  );

  assign cop_busy = busy_w;

  AST_STALL_IS_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stall == (iss_valid && !iss_ready)); // R8
  AST_TRAP_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_req && !cop_busy |=> !cop_busy); // R7

endmodule

// File: tb/test_cop_issue_interlock.sv
module test_cop_issue_interlock;
  localparam int LAT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_class = 2'd0;
  logic [LAT_W-1:0] iss_lat = '0;
  logic sby_we = 1'b0;
  logic [7:0] sby_wdata = 8'h00;
  logic iss_ready, stall, cop_dispatch, cop_busy, illegal_req;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int  m_remain = 0;
  bit  m_hold = 0;
  bit  m_sby = 0;

  always #4 clk = ~clk; // 125 MHz

  cop_issue_interlock #(.LAT_W(LAT_W), .SBY_W(8)) i_cop_issue_interlock (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_lat(iss_lat), .iss_ready(iss_ready), .stall(stall),
    .cop_dispatch(cop_dispatch), .cop_busy(cop_busy), .illegal_req(illegal_req),
    .sby_we(sby_we), .sby_wdata(sby_wdata)
  );

  task automatic chk(input bit act, input bit exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input int c, input int l, input bit we,
                      input logic [7:0] wd, input string tag);
    bit busy_e, rdy_e, disp_e, ill_e, stall_e, cop;
    @(negedge clk);
    iss_valid = v; iss_class = c[1:0]; iss_lat = l[LAT_W-1:0];
    sby_we = we; sby_wdata = wd;
    #1;
    cop     = (c != 0);
    busy_e  = (m_remain > 0);
    rdy_e   = !(busy_e && (m_hold || (cop && !m_sby)));
    disp_e  = v && rdy_e && cop && !m_sby;
    ill_e   = v && rdy_e && cop && m_sby;
    stall_e = v && !rdy_e;
    chk(cop_busy, busy_e, "cop_busy", tag);
    chk(iss_ready, rdy_e, "iss_ready", tag);
    chk(stall, stall_e, "stall", tag);
    chk(cop_dispatch, disp_e, "cop_dispatch", tag);
    chk(illegal_req, ill_e, "illegal_req", tag);
    @(posedge clk);
    if (disp_e) begin
      m_remain = l;
      m_hold   = (c >= 2);
    end else if (m_remain > 0) begin
      m_remain--;
    end
    if (m_remain == 0) m_hold = 0;
    if (we) m_sby = wd[1];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state
    step(0, 0, 0, 0, 8'h00, "R6 reset");
    // R1: integer instructions on idle coprocessor
    step(1, 0, 0, 0, 8'h00, "R1 int idle");
    step(1, 0, 7, 0, 8'h00, "R1 int idle lat ignored");
    // R2: local fp overlaps with integer work, R3 busy window
    step(1, 1, 5, 0, 8'h00, "R2 local dispatch");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h00, "R2 int overlap");
    // R4: second local op waits for the first
    for (int i = 0; i < 4; i++) step(1, 1, 2, 0, 8'h00, "R4 local waits");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'h00, "R3 drain");
    // R5: synchronizing ops hold integer side
    step(1, 2, 3, 0, 8'h00, "R5 sync dispatch");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 8'h00, "R5 int held");
    step(1, 3, 2, 0, 8'h00, "R5 copint dispatch");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h00, "R5 int held copint");
    // R4 then R5: sync behind a long local op
    step(1, 1, 6, 0, 8'h00, "R4 long local");
    for (int i = 0; i < 7; i++) step(1, 2, 2, 0, 8'h00, "R4 sync waits");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h00, "R5 hold after wait");
    // R9: latency zero
    step(1, 2, 0, 0, 8'h00, "R9 sync lat0");
    step(1, 0, 0, 0, 8'h00, "R9 next int");
    step(1, 1, 0, 0, 8'h00, "R9 local lat0");
    step(1, 1, 3, 0, 8'h00, "R9 next local");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h00, "R3 drain");
    // R6: write takes effect next cycle, only bit 1 matters
    step(1, 1, 2, 1, 8'h02, "R6 same-cycle old standby");
    step(1, 1, 2, 0, 8'h00, "R7 local trap");
    step(1, 2, 2, 0, 8'h00, "R7 sync trap");
    step(1, 3, 2, 0, 8'h00, "R7 copint trap");
    step(1, 0, 0, 0, 8'h00, "R7 int in standby");
    step(1, 1, 1, 1, 8'hFD, "R6 other bits set bit1 clear");
    step(1, 1, 1, 0, 8'h00, "R6 standby cleared");
    step(0, 0, 0, 1, 8'h01, "R6 bit0 only");
    step(1, 2, 1, 0, 8'h00, "R6 still active");
    step(1, 1, 4, 0, 8'h00, "R7 prior local");
    step(0, 0, 0, 1, 8'hFF, "R6 set all");
    step(1, 1, 3, 0, 8'h00, "R7 trap while busy");
    step(1, 2, 3, 0, 8'h00, "R7 trap while busy sync");
    step(0, 0, 0, 1, 8'h00, "R6 clear");
    // long pseudo-random phase compared every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      step((r & 3) != 0, (r >> 2) & 3, (r >> 4) % 7, ((r >> 8) & 31) == 0,
           8'((r >> 13) & 8'hFF), "R8 random");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule